// File: doc/BRIEF.md
# System-Control Coprocessor Register Decoder

This block sits beside a CPU core and services its coprocessor register transfers. Each transfer names a primary register number, a secondary register number and a second opcode field, and carries 32 bits of write data. The block decodes these coordinates into writes to a small set of control registers: data and instruction cache control, write-buffer control, a bank of protection-region descriptors, and the control words for the data and instruction tightly-coupled memories.

A few coordinate combinations have side effects instead of storing data. Writing the identification register (primary 0) asks the core for an undefined-instruction trap. One cache operation (primary 7, secondary 0, opcode2 4) asks the core to halt until an interrupt arrives. Only the two TCM control words can be read back; every other read returns zero. The first opcode field selects nothing in this register set and is not a port.

The block also decodes base addresses and sizes from the stored words so that the memory system can observe them. One protection region is shown at a time, chosen by a select input. The caches, the TCMs and protection enforcement are outside this block.

Top module: `cp_sysctl`

## Requirements
- R1: On reset every stored register, the read data and both request pulses are zero.
- R2: A write to primary 0 raises `undef_req` for exactly the one cycle after the write edge and leaves every stored register unchanged.
- R3: A write to primary 2 with opcode2 0 loads `dcache_ctl`, and one with opcode2 1 loads `icache_ctl`. Other opcode2 values change nothing.
- R4: A write to primary 3 loads `wbuf_ctl` only when opcode2 is 0.
- R5: A write to primary 6 loads protection region number `crm` when `crm` is below the region count (8). Any opcode2 is accepted. A `crm` of 8 or more changes nothing.
- R6: For the region chosen by `obs_sel`, `rgn_base` is the stored word with bits 11:0 cleared (the base field is bits 31:12, shifted left by 12). `rgn_size` is 2 shifted left by the 5-bit field in bits 5:1, so it is 33 bits wide.
- R7: A write to primary 7 with secondary 0 and opcode2 4 raises `halt_req` for exactly one cycle after the write edge. No other primary-7 write raises it.
- R8: A write to primary 9 with opcode2 0 loads the data TCM word, and one with opcode2 1 loads the instruction TCM word. Other opcode2 values change nothing. Each TCM base is its word with bits 11:0 cleared, and each size is 512 shifted left by bits 5:1, so it is 41 bits wide.
- R9: `rdata` is combinational. With `rd_en` high at primary 9 it returns the data TCM word for opcode2 0 and the instruction TCM word for opcode2 1. It is zero in every other case, including when `rd_en` is low.
- R10: A read and a write in the same cycle to the same TCM register return the value held before that write. The new value is readable from the next cycle on.
- R11: Writes to primaries 1, 4, 5, 8 and 10 to 15 change no register and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write transfer this cycle |
| rd_en | input | 1 | Register read transfer this cycle |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| op2 | input | 3 | Second opcode field |
| wdata | input | 32 | Write data |
| obs_sel | input | 3 | Protection region shown on the observation outputs |
| rdata | output | 32 | Read data |
| undef_req | output | 1 | Undefined-instruction trap request pulse |
| halt_req | output | 1 | Halt (wait for interrupt) request pulse |
| dcache_ctl | output | 32 | Data cache control word |
| icache_ctl | output | 32 | Instruction cache control word |
| wbuf_ctl | output | 32 | Write-buffer control word |
| dtcm_ctl | output | 32 | Data TCM control word |
| itcm_ctl | output | 32 | Instruction TCM control word |
| rgn_base | output | 32 | Decoded base of the selected region |
| rgn_size | output | 33 | Decoded size of the selected region |
| dtcm_base | output | 32 | Decoded data TCM base |
| dtcm_size | output | 41 | Decoded data TCM size |
| itcm_base | output | 32 | Decoded instruction TCM base |
| itcm_size | output | 41 | Decoded instruction TCM size |

## Verification
A read and a write can reach the same TCM control register in the same cycle. The bench forces this collision on purpose. It also lets random traffic assert both enables together. During the cycle before the edge the bench compares the combinational read data with its model's value from before the write. After the edge it compares the register output with the written word. A read that returned the new value early, or a store that was lost, is reported against R10.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;
  localparam int DW      = 32;
  localparam int BASE_LO = 12;
  localparam int SZ_LO   = 1;
  localparam int SZ_HI   = 5;
  localparam int RSIZE_W = DW + 1;
  localparam int TSIZE_W = DW + 9;

  typedef enum logic [3:0] {
    PRI_IDENT  = 4'd0,
    PRI_CACHE  = 4'd2,
    PRI_WBUF   = 4'd3,
    PRI_REGION = 4'd6,
    PRI_CACHOP = 4'd7,
    PRI_TCM    = 4'd9
  } pri_e;

  localparam logic [3:0] HALT_CRM = 4'd0;
  localparam logic [2:0] HALT_OP2 = 3'd4;

  typedef struct packed {
    logic dcache;
    logic icache;
    logic wbuf;
    logic dtcm;
    logic itcm;
    logic undef;
    logic halt;
  } wr_ev_t;

  function automatic logic [DW-1:0] field_base(input logic [DW-1:0] v);
    return {v[DW-1:BASE_LO], {BASE_LO{1'b0}}};
  endfunction

  function automatic logic [RSIZE_W-1:0] region_size(input logic [DW-1:0] v);
    return RSIZE_W'(2) << v[SZ_HI:SZ_LO];
  endfunction

  function automatic logic [TSIZE_W-1:0] tcm_size(input logic [DW-1:0] v);
    return TSIZE_W'(512) << v[SZ_HI:SZ_LO];
  endfunction
endpackage

// File: rtl/cpctl_wr_decode.sv
module cpctl_wr_decode
  import cpctl_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            wr_en,
  input  logic [3:0]      crn,
  input  logic [3:0]      crm,
  input  logic [2:0]      op2,
  output wr_ev_t          ev,
  output logic [NREG-1:0] rgn_we
);
  always_comb begin
    ev        = '0;
    ev.dcache = wr_en && (crn == PRI_CACHE) && (op2 == 3'd0);
    ev.icache = wr_en && (crn == PRI_CACHE) && (op2 == 3'd1);
    ev.wbuf   = wr_en && (crn == PRI_WBUF)  && (op2 == 3'd0);
    ev.dtcm   = wr_en && (crn == PRI_TCM)   && (op2 == 3'd0);
    ev.itcm   = wr_en && (crn == PRI_TCM)   && (op2 == 3'd1);
    ev.undef  = wr_en && (crn == PRI_IDENT);
    ev.halt   = wr_en && (crn == PRI_CACHOP) && (crm == HALT_CRM) && (op2 == HALT_OP2);
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rwe
    assign rgn_we[g] = wr_en && (crn == PRI_REGION) && (32'(crm) == g);
  end
endmodule

// File: rtl/cpctl_reg.sv
module cpctl_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/cpctl_rd_mux.sv
module cpctl_rd_mux
  import cpctl_pkg::*;
(
  input  logic          rd_en,
  input  logic [3:0]    crn,
  input  logic [2:0]    op2,
  input  logic [DW-1:0] dtcm_q,
  input  logic [DW-1:0] itcm_q,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en && crn == PRI_TCM) begin
      unique case (op2)
        3'd0:    rdata = dtcm_q;
        3'd1:    rdata = itcm_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cp_sysctl.sv
module cp_sysctl
  import cpctl_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [3:0]              crn,
  input  logic [3:0]              crm,
  input  logic [2:0]              op2,
  input  logic [31:0]             wdata,
  input  logic [$clog2(NREG)-1:0] obs_sel,
  output logic [31:0]             rdata,
  output logic                    undef_req,
  output logic                    halt_req,
  output logic [31:0]             dcache_ctl,
  output logic [31:0]             icache_ctl,
  output logic [31:0]             wbuf_ctl,
  output logic [31:0]             dtcm_ctl,
  output logic [31:0]             itcm_ctl,
  output logic [31:0]             rgn_base,
  output logic [32:0]             rgn_size,
  output logic [31:0]             dtcm_base,
  output logic [40:0]             dtcm_size,
  output logic [31:0]             itcm_base,
  output logic [40:0]             itcm_size
);
  localparam int NSCAL = 5;

  wr_ev_t          ev;
  logic [NREG-1:0] rgn_we;
  logic [DW-1:0]   rgn_q [NREG];
  logic [NSCAL-1:0] scal_we;
  logic [DW-1:0]   scal_q [NSCAL];

  // named decode events, visible to the bound checker
  logic ev_undef, ev_halt;
  assign ev_undef = ev.undef;
  assign ev_halt  = ev.halt;

  cpctl_wr_decode #(.NREG(NREG)) u_dec (
    .wr_en (wr_en),
    .crn   (crn),
    .crm   (crm),
    .op2   (op2),
    .ev    (ev),
    .rgn_we(rgn_we)
  );

  assign scal_we = {ev.itcm, ev.dtcm, ev.wbuf, ev.icache, ev.dcache};

  for (genvar s = 0; s < NSCAL; s++) begin : g_scal
    cpctl_reg #(.W(DW)) u_r (
      .clk(clk), .rst_n(rst_n), .we(scal_we[s]), .d(wdata), .q(scal_q[s])
    );
  end

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    cpctl_reg #(.W(DW)) u_r (
      .clk(clk), .rst_n(rst_n), .we(rgn_we[r]), .d(wdata), .q(rgn_q[r])
    );
  end

  assign dcache_ctl = scal_q[0];
  assign icache_ctl = scal_q[1];
  assign wbuf_ctl   = scal_q[2];
  assign dtcm_ctl   = scal_q[3];
  assign itcm_ctl   = scal_q[4];

  // side-effect requests: one-cycle pulses after the write edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      undef_req <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      undef_req <= ev_undef;
      halt_req  <= ev_halt;
    end
  end

  cpctl_rd_mux u_rd (
    .rd_en (rd_en),
    .crn   (crn),
    .op2   (op2),
    .dtcm_q(scal_q[3]),
    .itcm_q(scal_q[4]),
    .rdata (rdata)
  );

  assign rgn_base  = field_base(rgn_q[obs_sel]);
  assign rgn_size  = region_size(rgn_q[obs_sel]);
  assign dtcm_base = field_base(scal_q[3]);
  assign dtcm_size = tcm_size(scal_q[3]);
  assign itcm_base = field_base(scal_q[4]);
  assign itcm_size = tcm_size(scal_q[4]);
endmodule

// File: rtl/cp_sysctl_checker.sv
module cp_sysctl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  crn,
  input logic [3:0]  crm,
  input logic [2:0]  op2,
  input logic [31:0] rdata,
  input logic        undef_req,
  input logic        halt_req,
  input logic [31:0] dcache_ctl,
  input logic [31:0] icache_ctl,
  input logic [31:0] wbuf_ctl,
  input logic [31:0] dtcm_ctl,
  input logic [31:0] itcm_ctl,
  input logic        ev_undef,
  input logic        ev_halt
);
  a_r2_undef_follows_id_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && crn == 4'd0) |=> undef_req);

  a_r2_undef_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    undef_req |-> $past(wr_en && crn == 4'd0));

  a_r2_id_write_stores_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && crn == 4'd0) |=> ($stable(dcache_ctl) && $stable(icache_ctl) &&
      $stable(wbuf_ctl) && $stable(dtcm_ctl) && $stable(itcm_ctl)));

  a_r7_halt_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> halt_req);

  a_r7_halt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_en && crn == 4'd7 && crm == 4'd0 && op2 == 3'd4));

  a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_req && halt_req));

  a_r2_undef_decode_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_undef && ev_halt));

  a_r3_dcache_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dcache_ctl) |-> $past(wr_en && crn == 4'd2 && op2 == 3'd0));

  a_r4_wbuf_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wbuf_ctl) |-> $past(wr_en && crn == 4'd3 && op2 == 3'd0));

  a_r8_dtcm_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dtcm_ctl) |-> $past(wr_en && crn == 4'd9 && op2 == 3'd0));

  a_r9_read_zero_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || crn != 4'd9 || op2 > 3'd1) |-> (rdata == 32'd0));
endmodule

bind cp_sysctl cp_sysctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .crn(crn), .crm(crm),
  .op2(op2), .rdata(rdata), .undef_req(undef_req), .halt_req(halt_req),
  .dcache_ctl(dcache_ctl), .icache_ctl(icache_ctl), .wbuf_ctl(wbuf_ctl),
  .dtcm_ctl(dtcm_ctl), .itcm_ctl(itcm_ctl), .ev_undef(ev_undef), .ev_halt(ev_halt)
);

// File: tb/cp_sysctl_bench.sv
module cp_sysctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  crn = '0, crm = '0;
  logic [2:0]  op2 = '0, obs_sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, dcache_ctl, icache_ctl, wbuf_ctl, dtcm_ctl, itcm_ctl;
  logic        undef_req, halt_req;
  logic [31:0] rgn_base, dtcm_base, itcm_base;
  logic [32:0] rgn_size;
  logic [40:0] dtcm_size, itcm_size;

  int n_vec = 0, n_bad = 0;

  logic [31:0] m_dc, m_ic, m_wb, m_dt, m_it;
  logic [31:0] m_rg [8];

  always #10 clk = ~clk;

  cp_sysctl u_cp_sysctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .crn(crn), .crm(crm),
    .op2(op2), .wdata(wdata), .obs_sel(obs_sel), .rdata(rdata),
    .undef_req(undef_req), .halt_req(halt_req), .dcache_ctl(dcache_ctl),
    .icache_ctl(icache_ctl), .wbuf_ctl(wbuf_ctl), .dtcm_ctl(dtcm_ctl),
    .itcm_ctl(itcm_ctl), .rgn_base(rgn_base), .rgn_size(rgn_size),
    .dtcm_base(dtcm_base), .dtcm_size(dtcm_size), .itcm_base(itcm_base),
    .itcm_size(itcm_size)
  );

  function automatic logic [32:0] exp_rsize(input logic [31:0] v);
    logic [32:0] s = 33'd2;
    for (int i = 0; i < int'(v[5:1]); i++) s = s * 2;
    return s;
  endfunction

  function automatic logic [40:0] exp_tsize(input logic [31:0] v);
    logic [40:0] s = 41'd512;
    for (int i = 0; i < int'(v[5:1]); i++) s = s * 2;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic r, input logic [3:0] n,
                                           input logic [2:0] o);
    if (!r || n != 4'd9) return 32'd0;
    if (o == 3'd0) return m_dt;
    if (o == 3'd1) return m_it;
    return 32'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " dcache"}, 64'(dcache_ctl), 64'(m_dc));
    chk({req, " icache"}, 64'(icache_ctl), 64'(m_ic));
    chk({req, " wbuf"},   64'(wbuf_ctl),   64'(m_wb));
    chk({req, " dtcm"},   64'(dtcm_ctl),   64'(m_dt));
    chk({req, " itcm"},   64'(itcm_ctl),   64'(m_it));
    chk("R8 dtcm base", 64'(dtcm_base), 64'(m_dt & 32'hFFFF_F000));
    chk("R8 dtcm size", 64'(dtcm_size), 64'(exp_tsize(m_dt)));
    chk("R8 itcm base", 64'(itcm_base), 64'(m_it & 32'hFFFF_F000));
    chk("R8 itcm size", 64'(itcm_size), 64'(exp_tsize(m_it)));
    for (int k = 0; k < 8; k++) begin
      obs_sel = 3'(k);
      #1;
      chk("R5 region word via base/size R6", 64'(rgn_base), 64'(m_rg[k] & 32'hFFFF_F000));
      chk("R6 region size", 64'(rgn_size), 64'(exp_rsize(m_rg[k])));
    end
  endtask

  // starts and ends just after a falling edge
  task automatic xfer(input logic w, input logic r, input logic [3:0] n,
                      input logic [3:0] m, input logic [2:0] o, input logic [31:0] d,
                      input string req);
    logic e_undef, e_halt;
    wr_en = w; rd_en = r; crn = n; crm = m; op2 = o; wdata = d;
    #1;
    chk({req, " R9/R10 rdata"}, 64'(rdata), 64'(exp_read(r, n, o)));
    e_undef = w && n == 4'd0;
    e_halt  = w && n == 4'd7 && m == 4'd0 && o == 3'd4;
    @(posedge clk);
    if (w) begin
      case (n)
        4'd2: begin if (o == 3'd0) m_dc = d; else if (o == 3'd1) m_ic = d; end
        4'd3: if (o == 3'd0) m_wb = d;
        4'd6: if (m < 4'd8) m_rg[m[2:0]] = d;
        4'd9: begin if (o == 3'd0) m_dt = d; else if (o == 3'd1) m_it = d; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    #1;
    chk({req, " R2 undef_req"}, 64'(undef_req), 64'(e_undef));
    chk({req, " R7 halt_req"},  64'(halt_req),  64'(e_halt));
    chk_state(req);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] n, m;
    logic [2:0] o;
    logic [31:0] d;
    void'($urandom(32'd1234));
    m_dc = 0; m_ic = 0; m_wb = 0; m_dt = 0; m_it = 0;
    for (int k = 0; k < 8; k++) m_rg[k] = 0;

    repeat (3) @(negedge clk);
    #1;
    chk("R1 undef at reset", 64'(undef_req), 64'd0);
    chk("R1 halt at reset", 64'(halt_req), 64'd0);
    chk("R1 rdata at reset", 64'(rdata), 64'd0);
    chk_state("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    xfer(1, 0, 4'd2, 4'd0, 3'd0, 32'hA5A5_0001, "R3 dcache");
    xfer(1, 0, 4'd2, 4'd0, 3'd1, 32'h5A5A_0002, "R3 icache");
    xfer(1, 0, 4'd2, 4'd0, 3'd2, 32'hFFFF_FFFF, "R3 op2=2 ignored");
    xfer(1, 0, 4'd3, 4'd0, 3'd1, 32'h1111_1111, "R4 op2=1 ignored");
    xfer(1, 0, 4'd3, 4'd0, 3'd0, 32'h2222_2222, "R4 wbuf");
    xfer(1, 0, 4'd0, 4'd0, 3'd0, 32'hDEAD_BEEF, "R2 ident write");
    xfer(1, 0, 4'd7, 4'd0, 3'd4, 32'h0, "R7 halt op");
    xfer(1, 0, 4'd7, 4'd1, 3'd4, 32'h0, "R7 wrong crm");
    xfer(1, 0, 4'd7, 4'd0, 3'd3, 32'h0, "R7 wrong op2");
    xfer(1, 0, 4'd6, 4'd7, 3'd5, 32'h1234_503E, "R5 region7 size max R6");
    xfer(1, 0, 4'd6, 4'd9, 3'd0, 32'hFFFF_FFFF, "R5 crm=9 ignored");
    xfer(1, 0, 4'd9, 4'd0, 3'd0, 32'h0280_003E, "R8 dtcm size max");
    xfer(1, 1, 4'd9, 4'd0, 3'd0, 32'h0300_000A, "R10 write+read same cycle");
    xfer(0, 1, 4'd9, 4'd0, 3'd0, 32'h0, "R10 read after write");
    xfer(1, 1, 4'd9, 4'd1, 3'd1, 32'h0100_0014, "R10 itcm collision");
    xfer(0, 1, 4'd9, 4'd0, 3'd2, 32'h0, "R9 op2=2 reads zero");
    xfer(0, 1, 4'd2, 4'd0, 3'd0, 32'h0, "R9 dcache not readable");
    xfer(1, 0, 4'd5, 4'd0, 3'd0, 32'h7777_7777, "R11 primary 5");
    xfer(1, 0, 4'd15, 4'd0, 3'd0, 32'h7777_7777, "R11 primary 15");

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 8)
        0: n = 4'd0;  1: n = 4'd2;  2: n = 4'd3;  3: n = 4'd6;
        4: n = 4'd7;  5: n = 4'd9;  6: n = 4'd9;
        default: n = 4'($urandom);
      endcase
      m = ($urandom % 2) ? 4'($urandom % 10) : 4'd0;
      o = ($urandom % 2) ? 3'($urandom % 2) : 3'($urandom);
      d = $urandom;
      xfer(1'($urandom % 4 != 0), 1'($urandom % 2), n, m, o, d, "R11 random mix");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule